// File: doc/BRIEF.md
# Critical-Word-First Block Read Rotator

This block sits in the data path of a memory controller that moves whole blocks over a 64-bit bus. A block is four 64-bit beats. On a block read the whole block arrives from storage in natural order, together with the request address and a start strobe. The block then goes out one beat per cycle for four cycles. The beat that holds the requested word comes out first and the rest follow in cyclic order, wrapping past the last beat. The requester therefore gets the word it is waiting on as early as possible.

The lowest address bit selects a 32-bit half of a 64-bit word and plays no part in the ordering. The two address bits above it pick the leading beat. On the write side four incoming beats are placed back at their natural block positions, so a later rotated read returns a consistent view. For example, a block written as A, B, C, D and read at address 2 comes back as B, C, D, A.

Top module: `cwf_block_rotator`

## Requirements
- R1: After reset, `rd_valid` and `wr_done` are low and `wr_block` is all zeros.
- R2: The leading beat index is address bits [2:1], taken as ((addr >> 1) mod 4). Addresses 0, 2, 4 and 6 lead with beats 0, 1, 2 and 3. Address bit 0 has no effect on the order.
- R3: In the cycle after an accepted `rd_start`, `rd_data` carries beat S of the block, where S is the leading index. Beat i occupies `rd_block[64*i +: 64]`.
- R4: The following three cycles carry beats (S+1) mod 4, (S+2) mod 4 and (S+3) mod 4, in that order.
- R5: `rd_valid` is high for exactly four consecutive cycles, starting the cycle after an accepted `rd_start`, and drops afterwards unless a new transfer was accepted.
- R6: `rd_start` has no effect while a transfer is in progress, except in the cycle that presents the fourth beat. There it is accepted, and the next transfer follows with no gap.
- R7: The block and address are captured when `rd_start` is accepted. Later changes on `rd_block` or `rd_addr` do not alter the beats of that transfer.
- R8: A write is four beats on consecutive cycles, starting with the cycle where `wr_start` is high. Beat i is stored at `wr_block[64*i +: 64]`.
- R9: `wr_done` is high for exactly one cycle, the cycle after the fourth write beat is taken. In that cycle `wr_block` holds the complete new block.
- R10: `wr_start` raised during the last three beats of a write is ignored, and its data is taken as the ordinary next beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_start | input | 1 | Block read start strobe |
| rd_addr | input | 32 | Request address of the read |
| rd_block | input | 256 | Block from storage, beat i at bits 64*i+63:64*i |
| rd_valid | output | 1 | Read beat valid |
| rd_data | output | 64 | Rotated read beat |
| wr_start | input | 1 | First beat of a block write |
| wr_data | input | 64 | Write beat data |
| wr_block | output | 256 | Assembled block in natural order |
| wr_done | output | 1 | One-cycle pulse when a write block is complete |

## Verification
The bench builds the block with its default parameters: 64-bit beats, four beats per block, a 32-bit address and one half-word bit below the beat index. With these values the testbench walks every combination of the three low address bits. Each leading beat is therefore reached with both settings of the ignored half-word bit, and every wrap point of the rotation is covered. Because the block is only four beats, a strobe can be placed on each beat position of a running transfer, including the final beat, where a back-to-back start is legal.

// File: rtl/cwf_pkg.sv
package cwf_pkg;

  // Leading beat index: drop the half-word bits, then reduce modulo the beat count.
  function automatic int unsigned lead_beat(input longint unsigned addr,
                                            input int unsigned half_bits,
                                            input int unsigned beats);
    return int'((addr >> half_bits) % longint'(beats));
  endfunction

  // Beat index k steps after the leading one, wrapping at the beat count.
  function automatic int unsigned wrap_step(input int unsigned lead,
                                            input int unsigned k,
                                            input int unsigned beats);
    return (lead + k) % beats;
  endfunction

endpackage

// File: rtl/cwf_start_index.sv
module cwf_start_index #(
  parameter int ADDR_W    = 32,
  parameter int BEATS     = 4,
  parameter int HALF_BITS = 1,
  localparam int IDX_W    = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  lead_idx
);
  import cwf_pkg::*;

  always_comb begin
    lead_idx = IDX_W'(lead_beat(longint'(addr), HALF_BITS, BEATS));
  end
endmodule

// File: rtl/cwf_read_seq.sv
module cwf_read_seq #(
  parameter int BEATS  = 4,
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  output logic             accept,
  output logic             busy,
  output logic             last_beat,
  output logic [IDX_W-1:0] beat_cnt
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BEATS - 1);

  always_comb begin
    last_beat = busy && (beat_cnt == LAST);
    accept    = start_req && (!busy || last_beat);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      beat_cnt <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      beat_cnt <= '0;
    end else if (busy) begin
      if (last_beat) begin
        busy     <= 1'b0;
        beat_cnt <= '0;
      end else begin
        beat_cnt <= beat_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cwf_word_select.sv
module cwf_word_select #(
  parameter int DATA_W = 64,
  parameter int BEATS  = 4,
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic [BEATS*DATA_W-1:0] block,
  input  logic [IDX_W-1:0]        sel,
  output logic [DATA_W-1:0]       word
);
  logic [DATA_W-1:0] lanes [BEATS];

  for (genvar g = 0; g < BEATS; g++) begin : g_lane
    assign lanes[g] = block[g*DATA_W +: DATA_W];
  end

  always_comb begin
    word = '0;
    for (int i = 0; i < BEATS; i++) begin
      if (sel == IDX_W'(i)) word = lanes[i];
    end
  end
endmodule

// File: rtl/cwf_write_assembler.sv
module cwf_write_assembler #(
  parameter int DATA_W = 64,
  parameter int BEATS  = 4,
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_start,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [BEATS*DATA_W-1:0] wr_block,
  output logic                    wr_done,
  output logic                    wr_busy,
  output logic [IDX_W-1:0]        wr_cnt
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BEATS - 1);

  logic             take;
  logic [IDX_W-1:0] slot;
  logic             final_beat;

  always_comb begin
    take       = wr_busy || wr_start;
    slot       = wr_busy ? wr_cnt : '0;
    final_beat = take && (slot == LAST);
  end

  for (genvar g = 0; g < BEATS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        wr_block[g*DATA_W +: DATA_W] <= '0;
      else if (take && slot == IDX_W'(g))
        wr_block[g*DATA_W +: DATA_W] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_busy <= 1'b0;
      wr_cnt  <= '0;
      wr_done <= 1'b0;
    end else begin
      wr_done <= final_beat;
      if (final_beat) begin
        wr_busy <= 1'b0;
        wr_cnt  <= '0;
      end else if (take) begin
        wr_busy <= 1'b1;
        wr_cnt  <= slot + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cwf_block_rotator.sv
module cwf_block_rotator #(
  parameter int DATA_W    = 64,
  parameter int BEATS     = 4,
  parameter int ADDR_W    = 32,
  parameter int HALF_BITS = 1,
  localparam int IDX_W    = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int BLK_W    = BEATS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_start,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [BLK_W-1:0]  rd_block,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_start,
  input  logic [DATA_W-1:0] wr_data,
  output logic [BLK_W-1:0]  wr_block,
  output logic              wr_done
);
  import cwf_pkg::*;

  // Named internal events, visible to the bound checker.
  logic             accept;
  logic             busy;
  logic             last_beat;
  logic [IDX_W-1:0] beat_cnt;
  logic [IDX_W-1:0] addr_idx;
  logic [IDX_W-1:0] start_q;
  logic [IDX_W-1:0] beat_idx;
  logic [BLK_W-1:0] block_q;
  logic             wr_busy;
  logic [IDX_W-1:0] wr_cnt;

  cwf_start_index #(.ADDR_W(ADDR_W), .BEATS(BEATS), .HALF_BITS(HALF_BITS)) u_idx (
    .addr     (rd_addr),
    .lead_idx (addr_idx)
  );

  cwf_read_seq #(.BEATS(BEATS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (rd_start),
    .accept    (accept),
    .busy      (busy),
    .last_beat (last_beat),
    .beat_cnt  (beat_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      block_q <= '0;
    end else if (accept) begin
      start_q <= addr_idx;
      block_q <= rd_block;
    end
  end

  always_comb begin
    beat_idx = IDX_W'(wrap_step(int'(start_q), int'(beat_cnt), BEATS));
  end

  cwf_word_select #(.DATA_W(DATA_W), .BEATS(BEATS)) u_sel (
    .block (block_q),
    .sel   (beat_idx),
    .word  (rd_data)
  );

  assign rd_valid = busy;

  cwf_write_assembler #(.DATA_W(DATA_W), .BEATS(BEATS)) u_wr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_start (wr_start),
    .wr_data  (wr_data),
    .wr_block (wr_block),
    .wr_done  (wr_done),
    .wr_busy  (wr_busy),
    .wr_cnt   (wr_cnt)
  );
endmodule

// File: rtl/cwf_checker.sv
module cwf_checker #(
  parameter int BEATS  = 4,
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_start,
  input logic             rd_valid,
  input logic             accept,
  input logic             last_beat,
  input logic [IDX_W-1:0] addr_idx,
  input logic [IDX_W-1:0] start_q,
  input logic [IDX_W-1:0] beat_idx,
  input logic             wr_start,
  input logic             wr_busy,
  input logic [IDX_W-1:0] wr_cnt,
  input logic             wr_done
);
  AST_LEAD_FROM_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (beat_idx == $past(addr_idx)));  // R2

  AST_CYCLIC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(rd_valid) && !$past(accept)) |->
      (beat_idx == IDX_W'((32'($past(beat_idx)) + 1) % BEATS)));  // R4

  AST_VALID_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rd_valid);  // R5

  AST_VALID_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && !accept) |=> !rd_valid);  // R5

  AST_MIDSTREAM_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && rd_valid && !last_beat) |=> ($stable(start_q) && rd_valid));  // R6

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> ($past(wr_busy) && $past(wr_cnt) == IDX_W'(BEATS - 1)));  // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done);  // R9

  AST_WR_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_start && wr_busy) |=> (wr_cnt == IDX_W'(32'($past(wr_cnt)) + 1) || wr_done));  // R10
endmodule

bind cwf_block_rotator cwf_checker #(.BEATS(BEATS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_start  (rd_start),
  .rd_valid  (rd_valid),
  .accept    (accept),
  .last_beat (last_beat),
  .addr_idx  (addr_idx),
  .start_q   (start_q),
  .beat_idx  (beat_idx),
  .wr_start  (wr_start),
  .wr_busy   (wr_busy),
  .wr_cnt    (wr_cnt),
  .wr_done   (wr_done)
);

// File: tb/tb_cwf_block_rotator.sv
`timescale 1ns/1ps
module tb_cwf_block_rotator;
  localparam int DW = 64;
  localparam int NB = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            rd_start = 1'b0;
  logic [31:0]     rd_addr = '0;
  logic [NB*DW-1:0] rd_block = '0;
  logic            rd_valid;
  logic [DW-1:0]   rd_data;
  logic            wr_start = 1'b0;
  logic [DW-1:0]   wr_data = '0;
  logic [NB*DW-1:0] wr_block;
  logic            wr_done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  cwf_block_rotator dut (
    .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .rd_addr(rd_addr),
    .rd_block(rd_block), .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_start(wr_start), .wr_data(wr_data), .wr_block(wr_block), .wr_done(wr_done)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NB*DW-1:0] make_block(input int tag);
    logic [NB*DW-1:0] b;
    for (int i = 0; i < NB; i++) b[i*DW +: DW] = {16'hB10C, 16'(tag), 16'hBEA7, 16'(i)};
    return b;
  endfunction

  // Expected beat k of a read at address a: leading beat is bits [2:1].
  function automatic logic [DW-1:0] exp_word(input logic [NB*DW-1:0] b, input logic [31:0] a, input int k);
    int w;
    w = int'(a[2:1]) + k;
    if (w >= NB) w = w - NB;
    return b[w*DW +: DW];
  endfunction

  // Launch a read; returns at the negedge where beat 0 is visible. Block input is scrambled afterwards (R7).
  task automatic launch(input logic [31:0] a, input logic [NB*DW-1:0] b);
    @(negedge clk);
    rd_start = 1'b1; rd_addr = a; rd_block = b;
    @(negedge clk);
    rd_start = 1'b0; rd_addr = ~a; rd_block = ~b;
  endtask

  task automatic check_beats(input logic [31:0] a, input logic [NB*DW-1:0] b, input string tag);
    for (int k = 0; k < NB; k++) begin
      chk(rd_valid === 1'b1, {"R5 valid ", tag}, 256'(rd_valid), 256'(1));
      chk(rd_data === exp_word(b, a, k), (k == 0) ? {"R3 lead ", tag} : {"R4 order ", tag},
          256'(rd_data), 256'(exp_word(b, a, k)));
      if (k < NB - 1) @(negedge clk);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(rd_valid === 1'b0, "R1 rd_valid", 256'(rd_valid), 0);
    chk(wr_done === 1'b0, "R1 wr_done", 256'(wr_done), 0);
    chk(wr_block === '0, "R1 wr_block", wr_block, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_all_addresses;
    for (int a = 0; a < 8; a++) begin
      logic [NB*DW-1:0] b;
      b = make_block(a + 16);
      launch(32'(a) | 32'h0000_0100, b);
      check_beats(32'(a), b, $sformatf("R2 addr%0d", a));
      @(negedge clk);
      chk(rd_valid === 1'b0, "R5 drop", 256'(rd_valid), 0);
    end
  endtask

  task automatic t_midstream_ignored;
    logic [NB*DW-1:0] b;
    b = make_block(40);
    launch(32'd2, b);
    for (int k = 0; k < NB; k++) begin
      chk(rd_data === exp_word(b, 32'd2, k), "R6 ignored strobe", 256'(rd_data), 256'(exp_word(b, 32'd2, k)));
      rd_start = (k == 1);
      rd_addr  = 32'd6;
      rd_block = make_block(41);
      @(negedge clk);
    end
    rd_start = 1'b0;
    chk(rd_valid === 1'b0, "R6 no extra transfer", 256'(rd_valid), 0);
  endtask

  task automatic t_back_to_back;
    logic [NB*DW-1:0] b1, b2;
    b1 = make_block(50);
    b2 = make_block(51);
    launch(32'd4, b1);
    for (int k = 0; k < NB; k++) begin
      chk(rd_data === exp_word(b1, 32'd4, k), "R6 first run", 256'(rd_data), 256'(exp_word(b1, 32'd4, k)));
      if (k == NB - 1) begin rd_start = 1'b1; rd_addr = 32'd7; rd_block = b2; end
      @(negedge clk);
    end
    rd_start = 1'b0; rd_block = '0;
    check_beats(32'd7, b2, "R6 back-to-back");
    @(negedge clk);
    chk(rd_valid === 1'b0, "R5 drop after pair", 256'(rd_valid), 0);
  endtask

  task automatic t_write(input bit poke_start);
    logic [DW-1:0] d [NB];
    logic [NB*DW-1:0] e;
    for (int i = 0; i < NB; i++) begin
      d[i] = {32'h57A7_0000 + 32'(poke_start), 32'(i * 3 + 1)};
      e[i*DW +: DW] = d[i];
    end
    @(negedge clk);
    for (int i = 0; i < NB; i++) begin
      wr_start = (i == 0) || (poke_start && i == 2);
      wr_data  = d[i];
      @(negedge clk);
      if (i < NB - 1) chk(wr_done === 1'b0, "R9 early done", 256'(wr_done), 0);
    end
    wr_start = 1'b0; wr_data = '0;
    chk(wr_done === 1'b1, "R9 done pulse", 256'(wr_done), 1);
    chk(wr_block === e, poke_start ? "R10 block" : "R8 block", wr_block, e);
    @(negedge clk);
    chk(wr_done === 1'b0, "R9 single pulse", 256'(wr_done), 0);
  endtask

  initial begin
    t_reset();
    t_all_addresses();
    t_midstream_ignored();
    t_back_to_back();
    t_write(1'b0);
    t_write(1'b1);
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule